// File: doc/BRIEF.md
# Chained DMA channel controller

This block is one DMA channel that moves 32-bit words between a device-side word stream and memory. Software programs a current buffer as an address pointer that advances and an end address. It also programs a queued follow-on buffer as a first and an end address. When the current buffer runs out, the channel either switches to the queued buffer in the same cycle or halts, depending on a single-update flag. A copy of all four pointers is captured whenever the channel chains or hits a memory error, so software can put them back with one command and restart the transfer.

Control goes through a small register port. The control/status word is never read-modify-written. Each write carries command strobes in its middle byte, and the live flags are read back in its top byte. The memory side is a request port. The memory answers each request with an acknowledge and an optional error in the same cycle. The device side has two valid/ready streams, one for each direction. Only the one picked by the direction flag is live.

Back-pressure rules: in device-to-memory mode the channel requests memory only while `dev_in_valid` is high. It raises `dev_in_ready` only in a cycle where memory acknowledges without error, so a word is taken exactly when both are high. In memory-to-device mode the channel keeps requesting while it is enabled. `dev_out_valid` follows an error-free acknowledge, and a word is counted only when `dev_out_ready` is also high. A stalled device therefore causes the same address to be read again, and `next` does not move. `dev_out_valid` never depends on `dev_out_ready`.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset all status flags, all pointers and all saved copies read 0, `irq` is low and `mem_req` is low.
- R2: Register indices are 0 control/status, 1 next, 2 limit, 3 start, 4 stop, 5 to 8 the saved next, limit, start and stop (read-only; writes to them change nothing). Writes to next and start clear address bits 1:0. Writes to limit and stop clear bits 3:0.
- R3: When a buffer finishes while single update is clear, next and limit load start and stop at that clock edge. Complete is set, enable stays set and words keep moving from the new next.
- R4: Each accepted word advances next by 4. No word moves and next holds while enable is clear, or while the live stream side or memory is not ready.
- R5: A write to index 0 acts on these bits: 16 sets enable, 17 sets single update, 18 loads the direction (1 device-to-memory, 0 memory-to-device) on every such write, 19 clears complete, 20 clears enable, single update, complete and bus exception, and 21 restores the pointers. Within one write, clears take effect before sets.
- R6: Reading index 0 returns enable in bit 24, single update in 25, device-to-memory direction in 26, complete in 27 and bus exception in 28, with all other bits 0.
- R7: A memory error on a request sets bus exception and clears enable. The word is not accepted and next keeps the failing address.
- R8: When a buffer finishes while single update is set, enable clears and complete sets. next ends at limit and is not reloaded, and no further memory request is made.
- R9: `irq` is high while complete or bus exception is set. It goes low at the edge that takes a clear-complete or reset command, unless an event sets a flag in that same cycle.
- R10: On a chain, the saved copies take the values at that moment: saved next equals the old limit, and saved limit, start and stop equal the old limit, start and stop. On a memory error they take the current next, limit, start and stop.
- R11: The restore command (bit 21) loads next, limit, start and stop from their saved copies.
- R12: An enabled buffer whose next already equals its limit finishes on the following edge without any memory request.
- R13: In device-to-memory mode `mem_req` stays low while `dev_in_valid` is low. With `mem_ack` low, no word is taken in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Memory write word |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |
| mem_rdata | input | DATA_W | Memory read word, valid with `mem_ack` |
| dev_in_valid | input | 1 | Device offers a word for memory |
| dev_in_ready | output | 1 | Channel takes the offered word |
| dev_in_data | input | DATA_W | Word from the device |
| dev_out_valid | output | 1 | Channel offers a word to the device |
| dev_out_ready | input | 1 | Device takes the offered word |
| dev_out_data | output | DATA_W | Word to the device |
| irq | output | 1 | Complete or bus-exception pending |

## Verification
On every cycle the assertions check the following: no memory request is made while the channel is idle, an accepted word moves next by exactly one word, a chain loads the queued pair, single update drops enable, a memory error halts the channel, and a finished buffer raises the interrupt. Some behaviour can only be shown by the bench's scenarios: the exact read-back values of the status bits, the masking of pointer writes, the values captured in the saved copies, a restore after an error, the empty-buffer case and the data words that actually reach memory or the device.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  // command strobes in a control write
  localparam int CMD_SET_EN  = 16;
  localparam int CMD_SET_SUP = 17;
  localparam int CMD_DIR     = 18;
  localparam int CMD_CLR_CMP = 19;
  localparam int CMD_RESET   = 20;
  localparam int CMD_RESTORE = 21;
  localparam int CMD_LO      = CMD_SET_EN;
  localparam int CMD_W       = CMD_RESTORE - CMD_SET_EN + 1;

  // status bits in a control read
  localparam int ST_EN  = 24;
  localparam int ST_SUP = 25;
  localparam int ST_DIR = 26;
  localparam int ST_CMP = 27;
  localparam int ST_BEX = 28;

  // register indices
  localparam logic [3:0] RA_CSR      = 4'd0;
  localparam logic [3:0] RA_NEXT     = 4'd1;
  localparam logic [3:0] RA_LIMIT    = 4'd2;
  localparam logic [3:0] RA_START    = 4'd3;
  localparam logic [3:0] RA_STOP     = 4'd4;
  localparam logic [3:0] RA_SV_NEXT  = 4'd5;
  localparam logic [3:0] RA_SV_LIMIT = 4'd6;
  localparam logic [3:0] RA_SV_START = 4'd7;
  localparam logic [3:0] RA_SV_STOP  = 4'd8;

  localparam int NPTR = 4;  // next, limit, start, stop

  typedef struct packed {
    logic en;
    logic sup;
    logic dir;   // 1: device to memory
    logic cmp;
    logic bex;
  } flags_t;
endpackage

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              buf_done,
  input  logic              stop,
  input  logic              err,
  output flags_t            flags
);
  localparam int I_SET_EN  = CMD_SET_EN  - CMD_LO;
  localparam int I_SET_SUP = CMD_SET_SUP - CMD_LO;
  localparam int I_DIR     = CMD_DIR     - CMD_LO;
  localparam int I_CLR_CMP = CMD_CLR_CMP - CMD_LO;
  localparam int I_RESET   = CMD_RESET   - CMD_LO;

  logic do_rst, do_clr;
  assign do_rst = csr_wr & cmd[I_RESET];
  assign do_clr = csr_wr & (cmd[I_CLR_CMP] | cmd[I_RESET]);

  // clears first, then sets and hardware events
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags.en  <= (flags.en & ~do_rst & ~err & ~stop) | (csr_wr & cmd[I_SET_EN]);
      flags.sup <= (flags.sup & ~do_rst) | (csr_wr & cmd[I_SET_SUP]);
      flags.dir <= csr_wr ? cmd[I_DIR] : flags.dir;
      flags.cmp <= (flags.cmp & ~do_clr) | buf_done;
      flags.bex <= (flags.bex & ~do_rst) | err;
    end
  end
endmodule

// File: rtl/dmach_ptrs.sv
module dmach_ptrs
  import dmach_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STEP    = 4,
  parameter int BEG_LSB = 2,
  parameter int END_LSB = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_sel,
  input  logic [ADDR_W-1:0]          wdata,
  input  logic                       restore,
  input  logic                       chain,
  input  logic                       beat,
  input  logic                       snap,
  output logic [NPTR-1:0][ADDR_W-1:0] ptr,
  output logic [NPTR-1:0][ADDR_W-1:0] sv
);
  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    // odd slots (limit, stop) are end addresses
    localparam int LSB = (gi % 2 == 1) ? END_LSB : BEG_LSB;
    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} << LSB;
    logic [ADDR_W-1:0] q, sq, chain_v, snap_v;

    assign chain_v = (gi == 0) ? ptr[2] : ptr[3];
    assign snap_v  = (gi == 0 && chain) ? ptr[1] : q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (restore) begin
        q <= sq;
      end else if (wr_en && wr_sel == 2'(gi)) begin
        q <= wdata & MASK;
      end else if (chain && gi < 2) begin
        q <= chain_v;
      end else if (beat && gi == 0) begin
        q <= q + ADDR_W'(STEP);
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)    sq <= '0;
      else if (snap) sq <= snap_v;
    end

    assign ptr[gi] = q;
    assign sv[gi]  = sq;
  end
endmodule

// File: rtl/dmach_mover.sv
module dmach_mover #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              act,
  input  logic              dir,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [DATA_W-1:0] dev_out_data,
  output logic              beat,
  output logic              err
);
  logic ok;

  assign mem_req   = act & (dir ? dev_in_valid : 1'b1);
  assign mem_we    = dir;
  assign mem_addr  = addr;
  assign mem_wdata = dev_in_data;
  assign ok        = mem_req & mem_ack & ~mem_err;
  assign err       = mem_req & mem_ack & mem_err;

  assign dev_in_ready  = dir & ok;
  assign dev_out_valid = ~dir & ok;
  assign dev_out_data  = mem_rdata;

  assign beat = dir ? (dev_in_valid & dev_in_ready) : (dev_out_valid & dev_out_ready);
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dmach_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int BEG_LSB = 2,
  parameter int END_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [DATA_W-1:0] dev_out_data,
  output logic              irq
);
  localparam int STEP = DATA_W / 8;

  flags_t flags;
  logic [NPTR-1:0][ADDR_W-1:0] ptr, sv;
  logic en_q, sup_q, cmp_q, bex_q;
  logic [ADDR_W-1:0] next_q, limit_q, start_q, stop_q;
  logic csr_wr, ptr_wr, restore;
  logic [1:0] wr_sel;
  logic empty, last_word, act, beat, err, buf_done, chain, stop;

  assign en_q    = flags.en;
  assign sup_q   = flags.sup;
  assign cmp_q   = flags.cmp;
  assign bex_q   = flags.bex;
  assign next_q  = ptr[0];
  assign limit_q = ptr[1];
  assign start_q = ptr[2];
  assign stop_q  = ptr[3];

  assign csr_wr  = reg_wr_en && reg_addr == RA_CSR;
  assign ptr_wr  = reg_wr_en && reg_addr >= RA_NEXT && reg_addr <= RA_STOP;
  assign wr_sel  = 2'(reg_addr - RA_NEXT);
  assign restore = csr_wr & reg_wdata[CMD_RESTORE];

  assign empty     = next_q == limit_q;
  assign last_word = (next_q + ADDR_W'(STEP)) == limit_q;
  assign act       = en_q & ~empty;
  assign buf_done  = en_q & ~err & (empty | (beat & last_word));
  assign chain     = buf_done & ~sup_q;
  assign stop      = buf_done & sup_q;

  dmach_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr),
    .cmd(reg_wdata[CMD_LO +: CMD_W]),
    .buf_done(buf_done), .stop(stop), .err(err), .flags(flags)
  );

  dmach_ptrs #(.ADDR_W(ADDR_W), .STEP(STEP), .BEG_LSB(BEG_LSB), .END_LSB(END_LSB)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr), .wr_sel(wr_sel),
    .wdata(reg_wdata[ADDR_W-1:0]), .restore(restore), .chain(chain),
    .beat(beat), .snap(chain | err), .ptr(ptr), .sv(sv)
  );

  dmach_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mover (
    .act(act), .dir(flags.dir), .addr(next_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .beat(beat), .err(err)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CSR: begin
        reg_rdata[ST_EN]  = flags.en;
        reg_rdata[ST_SUP] = flags.sup;
        reg_rdata[ST_DIR] = flags.dir;
        reg_rdata[ST_CMP] = flags.cmp;
        reg_rdata[ST_BEX] = flags.bex;
      end
      RA_NEXT:     reg_rdata = 32'(ptr[0]);
      RA_LIMIT:    reg_rdata = 32'(ptr[1]);
      RA_START:    reg_rdata = 32'(ptr[2]);
      RA_STOP:     reg_rdata = 32'(ptr[3]);
      RA_SV_NEXT:  reg_rdata = 32'(sv[0]);
      RA_SV_LIMIT: reg_rdata = 32'(sv[1]);
      RA_SV_START: reg_rdata = 32'(sv[2]);
      RA_SV_STOP:  reg_rdata = 32'(sv[3]);
      default:     reg_rdata = '0;
    endcase
  end

  assign irq = flags.cmp | flags.bex;
endmodule

// File: rtl/dmach_checker.sv
module dmach_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              en_q,
  input logic              sup_q,
  input logic              bex_q,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              beat,
  input logic              chain,
  input logic              buf_done,
  input logic              irq,
  input logic [ADDR_W-1:0] next_q,
  input logic [ADDR_W-1:0] limit_q,
  input logic [ADDR_W-1:0] start_q,
  input logic [ADDR_W-1:0] stop_q
);
  // R4: an idle channel never touches memory
  a_r4_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !mem_req);

  // R4: one accepted word moves next by one word
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !chain && !reg_wr_en) |=> next_q == $past(next_q) + ADDR_W'(4));

  // R3: chain loads the queued pair
  a_r3_chain_load: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && !reg_wr_en) |=> (next_q == $past(start_q)) && (limit_q == $past(stop_q)));

  // R8: single update halts after the buffer
  a_r8_single_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_done && sup_q && !reg_wr_en) |=> !en_q);

  // R7: memory error halts and flags
  a_r7_err_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !reg_wr_en) |=> (!en_q && bex_q));

  // R9: a finished buffer raises the interrupt
  a_r9_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> irq);
endmodule

bind dma_chain_channel dmach_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en),
  .en_q(en_q), .sup_q(sup_q), .bex_q(bex_q),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err),
  .beat(beat), .chain(chain), .buf_done(buf_done), .irq(irq),
  .next_q(next_q), .limit_q(limit_q), .start_q(start_q), .stop_q(stop_q)
);

// File: tb/dma_chain_channel_tb.sv
module dma_chain_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_in_valid = 1'b0, dev_in_ready;
  logic [31:0] dev_in_data = '0;
  logic        dev_out_valid, dev_out_ready = 1'b0;
  logic [31:0] dev_out_data;
  logic        irq;

  logic        ack_en = 1'b1;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;

  int checks = 0;
  int failures = 0;
  int wr_cnt = 0;
  int req_cnt = 0;
  logic [31:0] last_waddr = '0, last_wdata = '0, last_out = '0;

  always #5 clk = ~clk;

  // memory model: answers in the same cycle
  assign mem_ack   = ack_en;
  assign mem_err   = err_en && (mem_addr == err_addr);
  assign mem_rdata = mem_addr ^ 32'hA5A5_0000;

  dma_chain_channel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .irq(irq)
  );

  always @(posedge clk) begin
    if (mem_req) req_cnt <= req_cnt + 1;
    if (mem_req && mem_ack && mem_we && !mem_err) begin
      wr_cnt     <= wr_cnt + 1;
      last_waddr <= mem_addr;
      last_wdata <= mem_wdata;
    end
    if (dev_out_valid && dev_out_ready) last_out <= dev_out_data;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pulse_out;
    @(negedge clk); dev_out_ready = 1'b1;
    @(negedge clk); dev_out_ready = 1'b0;
  endtask

  task automatic pulse_in(input logic [31:0] d);
    @(negedge clk); dev_in_valid = 1'b1; dev_in_data = d;
    @(negedge clk); dev_in_valid = 1'b0;
  endtask

  // {index, write data, expected read-back}
  localparam int NVEC = 8;
  localparam logic [67:0] VEC [NVEC] = '{
    {4'd1, 32'h0000_1003, 32'h0000_1000},
    {4'd2, 32'h0000_200F, 32'h0000_2000},
    {4'd3, 32'h0000_3006, 32'h0000_3004},
    {4'd4, 32'h0000_4019, 32'h0000_4010},
    {4'd5, 32'h0000_FFFF, 32'h0000_0000},
    {4'd8, 32'h0000_1234, 32'h0000_0000},
    {4'd1, 32'h0000_0105, 32'h0000_0104},
    {4'd2, 32'h0000_011C, 32'h0000_0110}
  };

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, v); check("R1 csr", v, 32'h0);
    rd(4'd1, v); check("R1 next", v, 32'h0);
    rd(4'd6, v); check("R1 saved limit", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 mem_req", 32'(mem_req), 32'h0);

    // R2 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][67:64], v);
      check("R2 pointer write", v, VEC[i][31:0]);
    end

    // memory to device, chaining (R3 R4 R10 R13)
    wr(4'd1, 32'h100); wr(4'd2, 32'h110); wr(4'd3, 32'h200); wr(4'd4, 32'h210);
    wr(4'd0, 32'h0001_0000);
    repeat (3) @(negedge clk);
    rd(4'd1, v); check("R4 no ready no move", v, 32'h100);
    ack_en = 1'b0;
    pulse_out();
    rd(4'd1, v); check("R13 no ack no move", v, 32'h100);
    ack_en = 1'b1;
    pulse_out(); pulse_out(); pulse_out();
    rd(4'd1, v); check("R4 next after 3 words", v, 32'h10C);
    check("R4 last data", last_out, 32'hA5A5_0108);
    rd(4'd0, v); check("R6 csr running", v, 32'h0100_0000);
    pulse_out();
    rd(4'd1, v); check("R3 next reload", v, 32'h200);
    rd(4'd2, v); check("R3 limit reload", v, 32'h210);
    rd(4'd0, v); check("R3 enable kept complete set", v, 32'h0900_0000);
    check("R9 irq on complete", 32'(irq), 32'h1);
    rd(4'd5, v); check("R10 saved next", v, 32'h110);
    rd(4'd6, v); check("R10 saved limit", v, 32'h110);
    rd(4'd7, v); check("R10 saved start", v, 32'h200);

    // R8 single update
    wr(4'd0, 32'h0002_0000);
    pulse_out(); pulse_out(); pulse_out(); pulse_out();
    rd(4'd0, v); check("R8 halted", v, 32'h0A00_0000);
    rd(4'd1, v); check("R8 next at limit", v, 32'h210);
    n0 = req_cnt;
    pulse_out(); pulse_out();
    check("R8 no further request", 32'(req_cnt - n0), 32'h0);
    wr(4'd0, 32'h0008_0000);
    #1 check("R9 irq drops on clear", 32'(irq), 32'h0);
    rd(4'd0, v); check("R5 clear complete keeps sup", v, 32'h0200_0000);

    // device to memory with a bus error (R7 R11 R13)
    wr(4'd0, 32'h0010_0000);
    wr(4'd1, 32'h300); wr(4'd2, 32'h320); wr(4'd3, 32'h400); wr(4'd4, 32'h410);
    err_en = 1'b1; err_addr = 32'h308;
    wr(4'd0, 32'h0005_0000);
    #1 check("R13 no valid no request", 32'(mem_req), 32'h0);
    pulse_in(32'hCAFE_0001);
    check("R4 write addr", last_waddr, 32'h300);
    check("R4 write data", last_wdata, 32'hCAFE_0001);
    pulse_in(32'hCAFE_0002);
    check("R4 second addr", last_waddr, 32'h304);
    n0 = wr_cnt;
    pulse_in(32'hCAFE_0003);
    check("R7 no write on error", 32'(wr_cnt - n0), 32'h0);
    rd(4'd0, v); check("R7 csr after error", v, 32'h1400_0000);
    rd(4'd1, v); check("R7 next held", v, 32'h308);
    rd(4'd5, v); check("R10 saved next on error", v, 32'h308);
    rd(4'd6, v); check("R10 saved limit on error", v, 32'h320);
    check("R9 irq on bus error", 32'(irq), 32'h1);
    err_en = 1'b0;
    wr(4'd1, 32'h500); wr(4'd4, 32'h7F0);
    wr(4'd0, 32'h0024_0000);
    rd(4'd1, v); check("R11 restored next", v, 32'h308);
    rd(4'd4, v); check("R11 restored stop", v, 32'h410);
    wr(4'd0, 32'h0014_0000);
    #1 check("R9 irq drops on reset", 32'(irq), 32'h0);
    rd(4'd0, v); check("R5 reset clears exception", v, 32'h0400_0000);

    // R12 empty buffer
    wr(4'd1, 32'h600); wr(4'd2, 32'h600);
    n0 = req_cnt;
    wr(4'd0, 32'h0003_0000);
    rd(4'd0, v); check("R12 empty completes", v, 32'h0A00_0000);
    check("R12 no request", 32'(req_cnt - n0), 32'h0);

    // R5 clears before sets in one write
    wr(4'd1, 32'h700); wr(4'd2, 32'h710);
    wr(4'd0, 32'h0011_0000);
    rd(4'd0, v); check("R5 reset then set enable", v, 32'h0100_0000);
    wr(4'd0, 32'h0010_0000);
    rd(4'd0, v); check("R5 reset stops", v, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule